// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that sits on a small 16-bit register bus. Software picks a timeout and then turns the watchdog on with a single control write. From then on, software must keep proving that it is alive. It does this by writing a fixed two-word key pair to the service register before the countdown runs out. If the countdown reaches its end, the block drives a system reset pulse of fixed length. It also leaves a sticky flag in the status register, so that software can tell later why the chip restarted.

Time is measured in half-second ticks. A parameterised prescaler derives these ticks from the input clock, so a simulation can use a very short tick. The timeout field is 8 bits wide, and the timeout is (field + 1) ticks. That gives a range from half a second up to 128 seconds in half-second steps. Once the watchdog is on, software cannot turn it off; only the block's own reset input does that.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, the reset output is low and reads of the control register (offset 0x0) and the status register (offset 0x4) return 0x0000.
- R2: A read strobe returns the addressed register on `rd_data` in the cycle after the strobe. Control reads show the timeout field in bits [15:8] and the enable in bit 2, with all other bits zero. Reads of the service register (offset 0x2) return zero.
- R3: A control write that sets bit 2 while the watchdog is off loads the countdown from the written field. With no servicing, the reset output rises exactly (field + 1) × TICK_DIV clock cycles after the clock edge that captured that write.
- R4: A field of 0 with enable set gives the shortest timeout: one tick, which is TICK_DIV cycles.
- R5: Once set, the enable bit stays set until the reset input is asserted. A control write with bit 2 clear leaves the enable at 1 and does not restart the countdown, although it does update the timeout field.
- R6: A service write of 0x5555, followed by a service write of 0xAAAA as the next service-register write, reloads the countdown to (field + 1) ticks from the edge that captured 0xAAAA. Writes to other registers in between do not break the pair.
- R7: Any service write that is not the expected next key sends the key detector back to waiting for 0x5555 and does not reload. This covers 0xAAAA on its own, 0x5555 followed by another value, and 0x5555 written twice.
- R8: On expiry, the reset output stays high for exactly RST_PULSE clock cycles.
- R9: On expiry, status bit 0 is set. It stays set, even after writes to the status register, until the reset input is asserted.
- R10: While the enable bit is clear, the countdown never expires and the reset output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Byte offset of the halfword register (0x0, 0x2, 0x4) |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after a read strobe |
| sys_rst_out | output | 1 | System reset pulse, active high |

## Verification
The assertions assume that every bus access is a single-cycle strobe to one of the three decoded offsets. They also assume that `rst_n` is held low for at least two clocks, so that the internal synchroniser settles. The bench drives each access for exactly one clock, between falling edges, and holds reset for three cycles. It always uses a timeout longer than the reset pulse, so that consecutive expiries never merge into one long pulse. Timing is measured from the edge that captures the enabling or service write.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;
  localparam int REG_W     = 16;
  localparam int FIELD_W   = 8;
  localparam int FIELD_LSB = 8;
  localparam int EN_BIT    = 2;
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'h0;
  localparam logic [ADDR_W-1:0] ADDR_SVC  = 3'h2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'h4;

  localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;

  typedef enum logic {KS_IDLE, KS_ARMED} key_state_e;
endpackage

// File: rtl/svc_wdog_prescaler.sv
module svc_wdog_prescaler #(
  parameter int TICK_DIV = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    cnt_d   = cnt_q;
    if (clear)
      cnt_d = '0;
    else if (run)
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    tick = run && !clear && at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/svc_wdog_keyseq.sv
module svc_wdog_keyseq
  import svc_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_wr,
  input  logic [REG_W-1:0] svc_data,
  output logic             svc_ok
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    svc_ok  = 1'b0;
    if (svc_wr) begin
      unique case (state_q)
        KS_IDLE:  state_d = (svc_data == KEY_FIRST) ? KS_ARMED : KS_IDLE;
        KS_ARMED: begin
          svc_ok  = (svc_data == KEY_SECOND);
          state_d = KS_IDLE;
        end
        default:  state_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/svc_wdog_countdown.sv
module svc_wdog_countdown
  import svc_wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic               reload,
  input  logic [FIELD_W-1:0] load_field,
  output logic               expire
);
  localparam int CNT_W = FIELD_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             last_tick;

  always_comb begin
    load_val  = {1'b0, load_field} + 1'b1;
    last_tick = (cnt_q == CNT_W'(1));
    expire    = run && tick && !reload && last_tick;
    cnt_d     = cnt_q;
    if (reload)
      cnt_d = load_val;
    else if (run && tick)
      cnt_d = last_tick ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/svc_wdog_pulse.sv
module svc_wdog_pulse #(
  parameter int RST_PULSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int LW = $clog2(RST_PULSE + 1);

  logic [LW-1:0] len_q, len_d;

  always_comb begin
    len_d = len_q;
    if (fire)
      len_d = LW'(RST_PULSE);
    else if (len_q != '0)
      len_d = len_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  assign active = (len_q != '0);
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wdog_pkg::*;
#(
  parameter int TICK_DIV  = 25_000_000,
  parameter int RST_PULSE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  rd_data,
  output logic              sys_rst_out
);
  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // register state
  logic [FIELD_W-1:0] ctrl_to_q, ctrl_to_d;
  logic               ctrl_en_q, ctrl_en_d;
  logic               flag_q, flag_d;
  logic [REG_W-1:0]   rdata_q, rdata_d;

  logic wr_ctrl, wr_svc, rd_any, en_rise;
  logic svc_ok, reload, tick, expire;
  logic [FIELD_W-1:0] load_field;
  logic [REG_W-1:0]   ctrl_word, stat_word;

  // names seen by the bound checker
  logic ctrl_en, status_flag;
  assign ctrl_en     = ctrl_en_q;
  assign status_flag = flag_q;

  always_comb begin
    wr_ctrl = bus_valid && bus_write && (bus_addr == ADDR_CTRL);
    wr_svc  = bus_valid && bus_write && (bus_addr == ADDR_SVC);
    rd_any  = bus_valid && !bus_write;
    en_rise = wr_ctrl && bus_wdata[EN_BIT] && !ctrl_en_q;

    load_field = wr_ctrl ? bus_wdata[FIELD_LSB +: FIELD_W] : ctrl_to_q;
    reload     = en_rise || (svc_ok && ctrl_en_q);

    ctrl_to_d = wr_ctrl ? bus_wdata[FIELD_LSB +: FIELD_W] : ctrl_to_q;
    ctrl_en_d = ctrl_en_q || en_rise;
    flag_d    = flag_q || expire;

    ctrl_word = '0;
    ctrl_word[FIELD_LSB +: FIELD_W] = ctrl_to_q;
    ctrl_word[EN_BIT]               = ctrl_en_q;
    stat_word    = '0;
    stat_word[0] = flag_q;

    rdata_d = rdata_q;
    if (rd_any) begin
      unique case (bus_addr)
        ADDR_CTRL: rdata_d = ctrl_word;
        ADDR_STAT: rdata_d = stat_word;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ctrl_to_q <= '0;
      ctrl_en_q <= 1'b0;
      flag_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ctrl_to_q <= ctrl_to_d;
      ctrl_en_q <= ctrl_en_d;
      flag_q    <= flag_d;
      rdata_q   <= rdata_d;
    end
  end

  svc_wdog_prescaler #(.TICK_DIV(TICK_DIV)) presc_i (
    .clk(clk), .rst_n(core_rst_n), .run(ctrl_en_q), .clear(reload), .tick(tick)
  );

  svc_wdog_keyseq keyseq_i (
    .clk(clk), .rst_n(core_rst_n), .svc_wr(wr_svc), .svc_data(bus_wdata), .svc_ok(svc_ok)
  );

  svc_wdog_countdown count_i (
    .clk(clk), .rst_n(core_rst_n), .run(ctrl_en_q), .tick(tick),
    .reload(reload), .load_field(load_field), .expire(expire)
  );

  svc_wdog_pulse #(.RST_PULSE(RST_PULSE)) pulse_i (
    .clk(clk), .rst_n(core_rst_n), .fire(expire), .active(sys_rst_out)
  );

  assign rd_data = rdata_q;
endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
  parameter int RST_PULSE = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sys_rst_out,
  input logic ctrl_en,
  input logic status_flag,
  input logic reload
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_cnt <= '0;
    else if (sys_rst_out) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
    else                  hi_cnt <= '0;
  end

  p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_out) |-> (hi_cnt >= 16'(RST_PULSE)));

  p_en_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> ctrl_en);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_flag |=> status_flag);

  p_flag_on_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_out) |-> status_flag);

  p_no_expiry_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !$rose(sys_rst_out));

  p_reload_blocks_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !$rose(sys_rst_out));
endmodule

bind svc_watchdog svc_watchdog_chk #(.RST_PULSE(RST_PULSE)) chk_i (
  .clk(clk), .rst_n(rst_n), .sys_rst_out(sys_rst_out),
  .ctrl_en(ctrl_en), .status_flag(status_flag), .reload(reload)
);

// File: tb/svc_watchdog_tb_top.sv
module svc_watchdog_tb_top;
  localparam int TB_DIV   = 5;
  localparam int TB_PULSE = 4;
  localparam int NVEC     = 6;
  // stimulus field and expected cycles to expiry, (field+1)*TB_DIV
  localparam logic [7:0] TV_FIELD [NVEC] = '{8'd0, 8'd1, 8'd3, 8'd7, 8'd128, 8'd255};
  localparam int         TV_CYC   [NVEC] = '{5, 10, 20, 40, 645, 1280};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = 3'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] rd_data;
  logic        sys_rst_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int t0 = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  svc_watchdog #(.TICK_DIV(TB_DIV), .RST_PULSE(TB_PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .sys_rst_out(sys_rst_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_rise(input int lim, output int t);
    while (!sys_rst_out && (cyc - t0) < lim) @(negedge clk);
    t = sys_rst_out ? (cyc - t0) : -1;
  endtask

  task automatic pulse_width(output int n);
    n = 0;
    while (sys_rst_out && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog timer expired in bench");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int t, w;

    // R1: reset state
    do_reset();
    chk("R1 rst out", int'(sys_rst_out), 0);
    rd(3'h0, d); chk("R1 ctrl", int'(d), 16'h0000);
    rd(3'h4, d); chk("R1 status", int'(d), 16'h0000);

    // R2, R10: field written without enable, no expiry
    wr(3'h0, 16'hA5F3);
    rd(3'h0, d); chk("R2 ctrl readback", int'(d), 16'hA500);
    rd(3'h2, d); chk("R2 svc reads zero", int'(d), 16'h0000);
    t0 = cyc; wait_rise(300, t);
    chk("R10 no expiry while off", t, -1);

    // R3, R4, R8, R9: table of timeouts
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      wr(3'h0, {TV_FIELD[i], 8'h04});
      t0 = cyc;
      wait_rise(3000, t);
      chk((TV_FIELD[i] == 0) ? "R4 min timeout" : "R3 timeout", t, TV_CYC[i]);
      pulse_width(w);
      chk("R8 pulse width", w, TB_PULSE);
      rd(3'h4, d); chk("R9 flag set", int'(d), 16'h0001);
    end

    // R9: status write ignored, rst_n clears
    wr(3'h4, 16'h0000);
    rd(3'h4, d); chk("R9 flag survives write", int'(d), 16'h0001);
    do_reset();
    rd(3'h4, d); chk("R9 flag cleared by reset", int'(d), 16'h0000);

    // R5: enable sticky, no restart on a clearing write
    wr(3'h0, 16'h0304);
    t0 = cyc;
    wr(3'h0, 16'h0300);
    rd(3'h0, d); chk("R5 enable sticky", int'(d), 16'h0304);
    wait_rise(200, t); chk("R5 no restart", t, 20);

    // R6: good key pair reloads
    do_reset();
    wr(3'h0, 16'h0304);
    repeat (10) @(negedge clk);
    wr(3'h2, 16'h5555); wr(3'h2, 16'hAAAA);
    t0 = cyc; wait_rise(200, t); chk("R6 reload", t, 20);

    // R6: status write between keys does not break pair
    do_reset();
    wr(3'h0, 16'h0304);
    repeat (10) @(negedge clk);
    wr(3'h2, 16'h5555); wr(3'h4, 16'h1234); wr(3'h2, 16'hAAAA);
    t0 = cyc; wait_rise(200, t); chk("R6 reload across other write", t, 20);

    // R7: broken pairs do not reload
    do_reset();
    wr(3'h0, 16'h0304); t0 = cyc;
    wr(3'h2, 16'h5555); wr(3'h2, 16'h1234); wr(3'h2, 16'hAAAA);
    wait_rise(200, t); chk("R7 wrong middle word", t, 20);

    do_reset();
    wr(3'h0, 16'h0304); t0 = cyc;
    wr(3'h2, 16'hAAAA);
    wait_rise(200, t); chk("R7 second key alone", t, 20);

    do_reset();
    wr(3'h0, 16'h0304); t0 = cyc;
    wr(3'h2, 16'h5555); wr(3'h2, 16'h5555); wr(3'h2, 16'hAAAA);
    wait_rise(200, t); chk("R7 first key twice", t, 20);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule